// File: doc/BRIEF.md
# Three-Wire Synchronous Serial Shifter

This block moves one byte at a time across a three-line synchronous serial link: a serial data input, a serial data output and a shift clock. The byte sits in an 8-bit shift register. Software loads it, starts the exchange by setting a busy flag, and reads back the received byte once busy drops. The same register is sent out most significant bit first while the incoming bits are shifted in behind it.

The block either drives the shift clock itself from a divided system clock (master role), or follows a shift clock supplied by the far end (slave role). In the slave role that clock passes through a two-flop synchronizer and an edge detector. The shift clock rests low between transfers. Software may end a transfer early by clearing busy, which leaves fewer than eight bits shifted. A one-cycle completion interrupt is raised when a full byte has gone through, provided it is enabled.

Top module: `tws_shifter`

## Requirements
- R1: While `rst` is high and in the cycle after it, `sck_out`, `sdo`, `busy` and `done_irq` are 0 and `rx_data` is 0x00.
- R2: In the master role (`ctl_master`=1), `ctl_rate` codes 0, 1, 2 and 3 give a shift-clock period of 2, 4, 8 and 16 system clocks.
- R3: Data moves MSB first. `sdo` shows bit 7 of the register, which is sampled on the rising shift-clock edge. The register shifts left on the falling edge, so `sdo` never changes while the clock stays high. After a full transfer, `rx_data` holds the eight received bits (first bit in bit 7), and the far end has received the loaded byte.
- R4: A `busy_set` pulse with `ctl_en`=1 raises `busy` in the next cycle. Hardware clears `busy` at the eighth falling shift-clock edge.
- R5: A `busy_clr` pulse stops a transfer. `busy` and `sck_out` go low, no interrupt is raised, and `rx_data` keeps the bits shifted so far.
- R6: When `irq_en`=1, `done_irq` pulses high for exactly one cycle as `busy` falls at the end of a full byte. When `irq_en`=0 there is no pulse.
- R7: `sck_out` is low whenever no master transfer is running. It is always low in the slave role.
- R8: A load (`ld_valid`) is taken only while the shift-clock level is low: `sck_out` in the master role, the synchronized `sck_in` in the slave role. A load while that level is high is ignored.
- R9: In the slave role the register shifts on synchronized `sck_in` edges in the same way as in the master role. Edges that arrive while `busy` is 0 leave `rx_data` and `sdo` unchanged.
- R10: With `ctl_en`=0, `busy_set` is ignored, `busy` is held at 0, and `sck_out` and `sdo` are held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Enables the shifter and its output lines |
| ctl_master | input | 1 | 1 = master (internal clock), 0 = slave (external clock) |
| ctl_rate | input | RATE_W | Master rate code, half period 2^code clocks |
| irq_en | input | 1 | Enables the completion interrupt |
| busy_set | input | 1 | Pulse: start a transfer |
| busy_clr | input | 1 | Pulse: stop the transfer early |
| ld_valid | input | 1 | Pulse: load `ld_data` into the shift register |
| ld_data | input | DATA_W | Byte to send |
| sdi | input | 1 | Serial data in |
| sck_in | input | 1 | External shift clock (slave role) |
| sdo | output | 1 | Serial data out |
| sck_out | output | 1 | Generated shift clock (master role) |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle completion interrupt |
| rx_data | output | DATA_W | Shift register contents |

## Verification
The bench checks the shift-clock period at each of the four rate codes. A divider that is off by one would show up there as a wrong period. It stops a slow master transfer after three bits and compares the partial byte. A design that kept shifting, or that fired the interrupt after a stop, would leave the wrong value or an extra pulse. It also holds the external clock high while issuing a load, and toggles it while idle. A design that took loads regardless of the clock level, or that shifted without `busy`, would corrupt the held byte. Finally, it sets `busy` with the block disabled, which must leave the lines quiet.

// File: rtl/tws_pkg.sv
package tws_pkg;
  typedef enum logic {ROLE_SLAVE = 1'b0, ROLE_MASTER = 1'b1} role_t;
endpackage

// File: rtl/tws_clkgen.sv
module tws_clkgen #(
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              sck,
  output logic              rise,
  output logic              fall
);
  localparam int CNT_W = 1 << RATE_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             tick;

  assign lim  = (CNT_W'(1) << rate) - CNT_W'(1);
  assign tick = run && (cnt == lim);
  assign rise = tick && !sck;
  assign fall = tick && sck;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R7: clock falls back to idle low once the run request drops
  p_sck_idle_r7: assert property (@(posedge clk) disable iff (rst) !run |=> !sck);
endmodule

// File: rtl/tws_edgesync.sv
module tws_edgesync (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic meta;
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= 1'b0;
      lvl  <= 1'b0;
      prev <= 1'b0;
    end else begin
      meta <= pin;
      lvl  <= meta;
      prev <= lvl;
    end
  end

  assign rise = lvl && !prev;
  assign fall = !lvl && prev;
endmodule

// File: rtl/tws_shreg.sv
module tws_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              cap,
  input  logic              shift,
  input  logic              sdi,
  output logic [DATA_W-1:0] data,
  output logic              sdo
);
  logic              cap_bit;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    if (shift)     nxt = {data[DATA_W-2:0], cap_bit};
    else if (load) nxt = ld_data;
    else           nxt = data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data    <= '0;
      cap_bit <= 1'b0;
      sdo     <= 1'b0;
    end else begin
      data <= nxt;
      if (cap) cap_bit <= sdi;
      sdo <= en && nxt[DATA_W-1];
    end
  end

  // R10: a disabled block drives its data line low
  p_sdo_off_r10: assert property (@(posedge clk) disable iff (rst) !en |=> !sdo);
endmodule

// File: rtl/tws_shifter.sv
module tws_shifter
  import tws_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_en,
  input  logic              ctl_master,
  input  logic [RATE_W-1:0] ctl_rate,
  input  logic              irq_en,
  input  logic              busy_set,
  input  logic              busy_clr,
  input  logic              ld_valid,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              sdi,
  input  logic              sck_in,
  output logic              sdo,
  output logic              sck_out,
  output logic              busy,
  output logic              done_irq,
  output logic [DATA_W-1:0] rx_data
);
  localparam int BC_W = $clog2(DATA_W + 1);

  role_t           role;
  logic            run_m;
  logic            m_sck, m_rise, m_fall;
  logic            s_lvl, s_rise, s_fall;
  logic            clk_lvl;
  logic            act, edge_rise, edge_fall;
  logic            got_rise;
  logic            last_bit;
  logic            load_ok;
  logic [BC_W-1:0] bit_cnt;

  assign role  = ctl_master ? ROLE_MASTER : ROLE_SLAVE;
  assign run_m = busy && ctl_en && (role == ROLE_MASTER);

  tws_clkgen #(.RATE_W(RATE_W)) u_clkgen (
    .clk(clk), .rst(rst), .run(run_m), .rate(ctl_rate),
    .sck(m_sck), .rise(m_rise), .fall(m_fall)
  );

  tws_edgesync u_sync (
    .clk(clk), .rst(rst), .pin(sck_in),
    .lvl(s_lvl), .rise(s_rise), .fall(s_fall)
  );

  assign clk_lvl   = (role == ROLE_MASTER) ? m_sck : s_lvl;
  assign act       = busy && ctl_en;
  assign edge_rise = act && ((role == ROLE_MASTER) ? m_rise : s_rise);
  assign edge_fall = act && got_rise && ((role == ROLE_MASTER) ? m_fall : s_fall);
  assign last_bit  = edge_fall && (bit_cnt == BC_W'(DATA_W - 1));
  assign load_ok   = ld_valid && !clk_lvl;

  tws_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk(clk), .rst(rst), .en(ctl_en), .load(load_ok), .ld_data(ld_data),
    .cap(edge_rise), .shift(edge_fall), .sdi(sdi),
    .data(rx_data), .sdo(sdo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      bit_cnt  <= '0;
      got_rise <= 1'b0;
      done_irq <= 1'b0;
    end else begin
      done_irq <= last_bit && irq_en;
      if (!ctl_en || busy_clr || last_bit) begin
        busy <= 1'b0;
      end else if (busy_set && !busy) begin
        busy    <= 1'b1;
        bit_cnt <= '0;
      end
      if (!act || edge_fall) got_rise <= 1'b0;
      else if (edge_rise)    got_rise <= 1'b1;
      if (edge_fall) bit_cnt <= bit_cnt + BC_W'(1);
    end
  end

  assign sck_out = m_sck;

  // R10: busy cannot survive a disabled cycle
  p_busy_off_r10: assert property (@(posedge clk) disable iff (rst) !ctl_en |=> !busy);
  // R6: interrupt is a single-cycle pulse
  p_irq_single_r6: assert property (@(posedge clk) disable iff (rst) done_irq |=> !done_irq);
  // R4: the interrupt coincides with busy dropping
  p_irq_at_end_r4: assert property (@(posedge clk) disable iff (rst) done_irq |-> $fell(busy));
  // R3: data out stays put while the shift clock remains high
  p_sdo_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (ctl_en && $past(ctl_en) && clk_lvl && $past(clk_lvl)) |-> $stable(sdo));
  // R7: no generated clock in the slave role
  p_no_clk_slave_r7: assert property (@(posedge clk) disable iff (rst)
    (!ctl_master && $past(!ctl_master)) |-> !sck_out);
endmodule

// File: tb/tws_shifter_bench.sv
module tws_shifter_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_en = 1'b0, ctl_master = 1'b1, irq_en = 1'b0;
  logic [1:0] ctl_rate = 2'd0;
  logic       busy_set = 1'b0, busy_clr = 1'b0, ld_valid = 1'b0;
  logic [7:0] ld_data = 8'h00;
  logic       sck_in = 1'b0, sl_sdi = 1'b0;
  logic       sdi, sdo, sck_out, busy, done_irq;
  logic [7:0] rx_data;

  logic [7:0] per_tx = 8'h00, per_rx = 8'h00;
  int checks = 0, errors = 0, cyc = 0, irq_cnt = 0, rise_n = 0;
  int rise_t0 = 0, rise_t1 = 0;

  always #4 clk = ~clk;

  assign sdi = ctl_master ? per_tx[7] : sl_sdi;

  tws_shifter u_tws_shifter (
    .clk(clk), .rst(rst), .ctl_en(ctl_en), .ctl_master(ctl_master),
    .ctl_rate(ctl_rate), .irq_en(irq_en), .busy_set(busy_set),
    .busy_clr(busy_clr), .ld_valid(ld_valid), .ld_data(ld_data),
    .sdi(sdi), .sck_in(sck_in), .sdo(sdo), .sck_out(sck_out),
    .busy(busy), .done_irq(done_irq), .rx_data(rx_data)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (done_irq) irq_cnt <= irq_cnt + 1;
  end
  always @(posedge sck_out) begin
    per_rx <= {per_rx[6:0], sdo};
    if (rise_n == 0) rise_t0 = cyc;
    if (rise_n == 1) rise_t1 = cyc;
    rise_n = rise_n + 1;
  end
  always @(negedge sck_out) per_tx <= {per_tx[6:0], 1'b0};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int period_of(input int rate);
    return 2 << rate;
  endfunction

  task automatic load_byte(input logic [7:0] d);
    @(negedge clk) ld_valid = 1'b1; ld_data = d;
    @(negedge clk) ld_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int t = 0; t < 3000 && busy; t++) @(negedge clk);
  endtask

  task automatic master_xfer(input int rate, input logic [7:0] d, input logic [7:0] p, input logic ie);
    int irq0;
    @(negedge clk) ctl_master = 1'b1; ctl_rate = 2'(rate); irq_en = ie; per_tx = p;
    load_byte(d);
    @(negedge clk) busy_set = 1'b1; rise_n = 0; irq0 = irq_cnt;
    @(negedge clk) busy_set = 1'b0;
    chk("R4 busy raised", int'(busy), 1);
    wait_idle();
    @(negedge clk);
    chk("R4 busy cleared", int'(busy), 0);
    chk("R3 received byte", int'(rx_data), int'(p));
    chk("R3 far end byte", int'(per_rx), int'(d));
    chk("R2 clock period", rise_t1 - rise_t0, period_of(rate));
    chk("R6 irq count", irq_cnt - irq0, int'(ie));
    chk("R7 clock idle", int'(sck_out), 0);
  endtask

  task automatic slave_xfer(input logic [7:0] d, input logic [7:0] p, input logic ie);
    int irq0;
    logic [7:0] got;
    got = 8'h00;
    @(negedge clk) ctl_master = 1'b0; irq_en = ie; sck_in = 1'b0;
    repeat (4) @(negedge clk);
    load_byte(d);
    @(negedge clk) busy_set = 1'b1; irq0 = irq_cnt;
    @(negedge clk) busy_set = 1'b0;
    for (int i = 0; i < 8; i++) begin
      sl_sdi = p[7-i];
      repeat (6) @(negedge clk);
      got = {got[6:0], sdo};
      sck_in = 1'b1;
      repeat (6) @(negedge clk);
      sck_in = 1'b0;
    end
    repeat (8) @(negedge clk);
    chk("R9 slave received", int'(rx_data), int'(p));
    chk("R9 slave sent", int'(got), int'(d));
    chk("R4 slave busy cleared", int'(busy), 0);
    chk("R6 slave irq count", irq_cnt - irq0, int'(ie));
    chk("R7 no clock as slave", int'(sck_out), 0);
  endtask

  initial begin
    repeat (5000 * 30) @(negedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd7741));
    repeat (4) @(negedge clk);
    chk("R1 reset sck", int'(sck_out), 0);
    chk("R1 reset busy", int'(busy), 0);
    @(negedge clk) rst = 1'b0;
    chk("R1 reset sdo", int'(sdo), 0);
    chk("R1 reset irq", int'(done_irq), 0);
    chk("R1 reset data", int'(rx_data), 0);

    // R10: disabled block
    load_byte(8'h80);
    @(negedge clk) busy_set = 1'b1;
    @(negedge clk) busy_set = 1'b0;
    repeat (20) @(negedge clk);
    chk("R10 busy ignored", int'(busy), 0);
    chk("R10 clock quiet", int'(sck_out), 0);
    chk("R10 sdo quiet", int'(sdo), 0);
    ctl_en = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 sdo after enable", int'(sdo), 1);

    // directed: each rate with fixed bytes
    for (int r = 0; r < 4; r++) master_xfer(r, 8'hC3, 8'h5A ^ 8'(r), 1'b1);

    // R5: early stop after three bits at the slowest rate
    @(negedge clk) ctl_rate = 2'd3; irq_en = 1'b1; per_tx = 8'h3C;
    load_byte(8'hA5);
    @(negedge clk) busy_set = 1'b1; held = 8'h00;
    @(negedge clk) busy_set = 1'b0;
    begin
      int irq0;
      irq0 = irq_cnt;
      repeat (3) @(negedge sck_out);
      @(negedge clk) busy_clr = 1'b1;
      @(negedge clk) busy_clr = 1'b0;
      chk("R5 busy stopped", int'(busy), 0);
      repeat (40) @(negedge clk);
      chk("R5 clock parked", int'(sck_out), 0);
      chk("R5 partial byte", int'(rx_data), int'(((8'hA5 << 3) | (8'h3C >> 5)) & 8'hFF));
      chk("R5 no irq", irq_cnt - irq0, 0);
    end

    // R8 and R9: slave role, busy clear
    @(negedge clk) ctl_master = 1'b0; sck_in = 1'b0;
    repeat (4) @(negedge clk);
    load_byte(8'h5A);
    repeat (2) @(negedge clk);
    chk("R8 load while low", int'(rx_data), 8'h5A);
    sck_in = 1'b1;
    repeat (4) @(negedge clk);
    load_byte(8'hFF);
    sck_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R8 load while high ignored", int'(rx_data), 8'h5A);
    for (int i = 0; i < 3; i++) begin
      sck_in = 1'b1; repeat (5) @(negedge clk);
      sck_in = 1'b0; repeat (5) @(negedge clk);
    end
    chk("R9 idle edges data", int'(rx_data), 8'h5A);
    chk("R9 idle edges sdo", int'(sdo), 0);

    // random mix
    for (int k = 0; k < 10; k++)
      master_xfer(int'($urandom_range(0, 3)), 8'($urandom), 8'($urandom), 1'($urandom));
    for (int k = 0; k < 4; k++)
      slave_xfer(8'($urandom), 8'($urandom), 1'($urandom));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule